// File: doc/BRIEF.md
# Timer Master Trigger Output Selector

This block produces the two trigger outputs that a general-purpose timer hands to other peripherals. The primary output picks one of eight sources: the counter reset event, the counter-enable level, the update event, the compare pulse event, or one of the compare reference levels 1 to 4. The secondary output adds eight more sources. Two of them are the compare reference levels 5 and 6. The other six are single-cycle pulses taken from edges of references 4, 5 and 6, either on one channel or ORed across two channels.

Both selector fields sit in a control word that a plain read/write port reaches. A separate event word holds a self-clearing update-generation bit. Software sets that bit to force an update event. A build-time parameter removes the secondary output. The secondary field is then not stored and reads as zero, so software can detect the capability by writing all ones and reading the word back.

Top module: `tmr_trig_sel`

## Requirements
- R1: After reset both trigger outputs are low and the control word (address 0) reads zero.
- R2: The primary selector is at control bits 6:4 and the secondary selector at bits 23:20. Both read back the last written value, and all other control bits read zero. The event word (address 1) always reads zero.
- R3: When the secondary output is absent (HAS_TRGO2=0), control bits 23:20 ignore writes and read zero, and the secondary output stays low.
- R4: The primary output registers its selected source with one cycle of latency. The codes are 0 reset event, 1 enable level, 2 update event, 3 compare pulse event, and 4 to 7 reference levels 1 to 4.
- R5: The secondary output uses codes 0 to 7 exactly as R4. Code 8 selects reference level 5 and code 9 reference level 6, also with one cycle of latency.
- R6: On the secondary output, code 10 gives a one-cycle pulse on any edge of reference 4, and code 11 does the same for reference 6. The pulse appears one cycle after the edge is sampled.
- R7: On the secondary output, code 12 pulses on a rising edge of reference 4 or a rising edge of reference 6. Code 13 pulses on a rising edge of reference 4 or a falling edge of reference 6.
- R8: On the secondary output, code 14 pulses on a rising edge of reference 5 or a rising edge of reference 6. Code 15 pulses on a rising edge of reference 5 or a falling edge of reference 6.
- R9: Writing 1 to event-word bit 0 produces a one-cycle update event. A trigger output in update mode pulses high for one cycle, two cycles after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Word address: 0 control, 1 event |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data for reg_addr_i, combinational |
| ev_reset_i | input | 1 | Counter reset event pulse |
| ev_enable_i | input | 1 | Counter enable level |
| ev_update_i | input | 1 | Counter update event pulse |
| ev_cmp_i | input | 1 | Compare pulse event |
| oc_ref_i | input | N_OC | Compare reference levels, bit 0 is reference 1 |
| trgo_o | output | 1 | Primary trigger output |
| trgo2_o | output | 1 | Secondary trigger output |

## Verification
The mixed-edge modes are the hardest to reach. Codes 13 and 15 must ignore a rising edge on reference 6 yet fire on its falling edge. Code 12 must give two separate pulses when references 4 and 6 rise at different times within one period. The stimulus holds every reference quiet, selects each edge code, and then drives one reference at a time through a rise and a fall. The output is checked on the cycle after each edge and on the cycle after that. A second instance built without the secondary output receives the same all-ones write, which exercises the capability probe.

// File: rtl/tts_pkg.sv
package tts_pkg;
  localparam int unsigned NUM_SRC = 16;

  typedef enum logic [3:0] {
    SRC_RST  = 4'd0,
    SRC_EN   = 4'd1,
    SRC_UPD  = 4'd2,
    SRC_CMP  = 4'd3,
    SRC_OC1  = 4'd4,
    SRC_OC2  = 4'd5,
    SRC_OC3  = 4'd6,
    SRC_OC4  = 4'd7,
    SRC_OC5  = 4'd8,
    SRC_OC6  = 4'd9,
    SRC_E4   = 4'd10,
    SRC_E6   = 4'd11,
    SRC_R4R6 = 4'd12,
    SRC_R4F6 = 4'd13,
    SRC_R5R6 = 4'd14,
    SRC_R5F6 = 4'd15
  } src_e;
endpackage

// File: rtl/tts_regs.sv
module tts_regs #(
  parameter int unsigned DW        = 32,
  parameter int unsigned AW        = 2,
  parameter int unsigned SEL1_LSB  = 4,
  parameter int unsigned SEL1_W    = 3,
  parameter int unsigned SEL2_LSB  = 20,
  parameter int unsigned SEL2_W    = 4,
  parameter bit          HAS_TRGO2 = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [SEL1_W-1:0] sel1_o,
  output logic [SEL2_W-1:0] sel2_o,
  output logic              ug_o
);
  localparam logic [AW-1:0] ADDR_CTRL = '0;
  localparam logic [AW-1:0] ADDR_EVT  = AW'(1);

  logic wr_ctrl, wr_evt;
  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL);
  assign wr_evt  = we_i && (addr_i == ADDR_EVT);

  logic [SEL1_W-1:0] sel1_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel1_q <= '0;
    else if (wr_ctrl) sel1_q <= wdata_i[SEL1_LSB +: SEL1_W];
  end
  assign sel1_o = sel1_q;

  generate
    if (HAS_TRGO2) begin : g_sel2
      logic [SEL2_W-1:0] sel2_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      sel2_q <= '0;
        else if (wr_ctrl) sel2_q <= wdata_i[SEL2_LSB +: SEL2_W];
      end
      assign sel2_o = sel2_q;
    end else begin : g_nosel2
      assign sel2_o = '0;
    end
  endgenerate

  // update-generation strobe: one cycle, never stored
  logic ug_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ug_q <= 1'b0;
    else         ug_q <= wr_evt && wdata_i[0];
  end
  assign ug_o = ug_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL) begin
      rdata_o[SEL1_LSB +: SEL1_W] = sel1_q;
      rdata_o[SEL2_LSB +: SEL2_W] = sel2_o;
    end
  end

  assert_ug_self_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ug_q && !(wr_evt && wdata_i[0])) |=> !ug_q);
endmodule

// File: rtl/tts_src.sv
module tts_src
  import tts_pkg::*;
#(
  parameter int unsigned N_OC = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ev_reset_i,
  input  logic               ev_enable_i,
  input  logic               ev_update_i,
  input  logic               ev_cmp_i,
  input  logic               ug_i,
  input  logic [N_OC-1:0]    oc_ref_i,
  output logic [NUM_SRC-1:0] src_o
);
  localparam int unsigned I4 = 3;
  localparam int unsigned I5 = 4;
  localparam int unsigned I6 = 5;

  logic [N_OC-1:0] oc_q, rise, fall;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oc_q <= '0;
    else         oc_q <= oc_ref_i;
  end
  assign rise = oc_ref_i & ~oc_q;
  assign fall = ~oc_ref_i & oc_q;

  assign src_o[SRC_RST] = ev_reset_i;
  assign src_o[SRC_EN]  = ev_enable_i;
  assign src_o[SRC_UPD] = ev_update_i | ug_i;
  assign src_o[SRC_CMP] = ev_cmp_i;

  generate
    for (genvar k = 0; k < N_OC; k++) begin : g_lvl
      assign src_o[int'(SRC_OC1) + k] = oc_ref_i[k];
    end
  endgenerate

  assign src_o[SRC_E4]   = rise[I4] | fall[I4];
  assign src_o[SRC_E6]   = rise[I6] | fall[I6];
  assign src_o[SRC_R4R6] = rise[I4] | rise[I6];
  assign src_o[SRC_R4F6] = rise[I4] | fall[I6];
  assign src_o[SRC_R5R6] = rise[I5] | rise[I6];
  assign src_o[SRC_R5F6] = rise[I5] | fall[I6];
endmodule

// File: rtl/tts_mux.sv
module tts_mux #(
  parameter int unsigned SEL_W = 3,
  parameter bit          EN    = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [2**SEL_W-1:0] src_i,
  output logic                out_o
);
  generate
    if (EN) begin : g_on
      logic out_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= 1'b0;
        else         out_q <= src_i[sel_i];
      end
      assign out_o = out_q;
    end else begin : g_off
      logic unused_in;
      assign unused_in = ^{sel_i, src_i};
      assign out_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tmr_trig_sel.sv
module tmr_trig_sel
  import tts_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned AW        = 2,
  parameter int unsigned N_OC      = 6,
  parameter bit          HAS_TRGO2 = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  input  logic            ev_reset_i,
  input  logic            ev_enable_i,
  input  logic            ev_update_i,
  input  logic            ev_cmp_i,
  input  logic [N_OC-1:0] oc_ref_i,
  output logic            trgo_o,
  output logic            trgo2_o
);
  localparam int unsigned SEL1_W   = 3;
  localparam int unsigned SEL2_W   = $clog2(NUM_SRC);
  localparam int unsigned SEL1_LSB = 4;
  localparam int unsigned SEL2_LSB = 20;

  logic [SEL1_W-1:0]  sel1;
  logic [SEL2_W-1:0]  sel2;
  logic               ug;
  logic [NUM_SRC-1:0] src;

  tts_regs #(
    .DW(DW), .AW(AW), .SEL1_LSB(SEL1_LSB), .SEL1_W(SEL1_W),
    .SEL2_LSB(SEL2_LSB), .SEL2_W(SEL2_W), .HAS_TRGO2(HAS_TRGO2)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .sel1_o(sel1), .sel2_o(sel2), .ug_o(ug)
  );

  tts_src #(.N_OC(N_OC)) u_src (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ev_reset_i(ev_reset_i), .ev_enable_i(ev_enable_i),
    .ev_update_i(ev_update_i), .ev_cmp_i(ev_cmp_i),
    .ug_i(ug), .oc_ref_i(oc_ref_i), .src_o(src)
  );

  tts_mux #(.SEL_W(SEL1_W), .EN(1'b1)) u_mux1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel1),
    .src_i(src[2**SEL1_W-1:0]), .out_o(trgo_o)
  );

  tts_mux #(.SEL_W(SEL2_W), .EN(HAS_TRGO2)) u_mux2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel2),
    .src_i(src), .out_o(trgo2_o)
  );

  // cycles since reset, saturating at 2, gates $past-based checks
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
  end

  assert_oc6_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2 && $past(sel2) == SEL2_W'(SRC_OC6)) |-> (trgo2_o == $past(oc_ref_i[5])));

  assert_r4r6_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2 && $past(sel2) == SEL2_W'(SRC_R4R6) && trgo2_o) |->
      (($past(oc_ref_i[3]) && !$past(oc_ref_i[3], 2)) ||
       ($past(oc_ref_i[5]) && !$past(oc_ref_i[5], 2))));

  assert_upd_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q != 2'd0 && $past(sel1) == 3'd2) |-> (trgo_o == $past(ev_update_i || ug)));

  generate
    if (!HAS_TRGO2) begin : g_absent_chk
      assert_absent_rd_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rdata_o[SEL2_LSB +: SEL2_W] == '0) && !trgo2_o);
    end
  endgenerate
endmodule

// File: tb/tb_tmr_trig_sel.sv
`timescale 1ns/1ps
module tb_tmr_trig_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_nt;
  logic        ev_rst = 1'b0, ev_en = 1'b0, ev_upd = 1'b0, ev_cmp = 1'b0;
  logic [5:0]  oc = '0;
  logic        trgo, trgo2, trgo_nt, trgo2_nt;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  tmr_trig_sel #(.HAS_TRGO2(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ev_reset_i(ev_rst), .ev_enable_i(ev_en), .ev_update_i(ev_upd),
    .ev_cmp_i(ev_cmp), .oc_ref_i(oc), .trgo_o(trgo), .trgo2_o(trgo2)
  );

  tmr_trig_sel #(.HAS_TRGO2(1'b0)) dut_nt (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata_nt),
    .ev_reset_i(ev_rst), .ev_enable_i(ev_en), .ev_update_i(ev_upd),
    .ev_cmp_i(ev_cmp), .oc_ref_i(oc), .trgo_o(trgo_nt), .trgo2_o(trgo2_nt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = '0; wdata = '0;
  endtask

  function automatic logic [31:0] ctl(input int s1, input int s2);
    return (32'(s1) << 4) | (32'(s2) << 20);
  endfunction

  task automatic t_reset();
    #1;
    chk("R1 trgo", 32'(trgo), 0);
    chk("R1 trgo2", 32'(trgo2), 0);
    chk("R1 ctrl", rdata, 0);
    @(negedge clk); rst_n = 1'b1; step();
    chk("R1 ctrl after release", rdata, 0);
  endtask

  task automatic t_ctrl_rw();
    wr(0, 32'hFFFF_FFFF);
    #1; chk("R2 all-ones readback", rdata, 32'h00F0_0070);
    chk("R3 absent readback", rdata_nt, 32'h0000_0070);
    wr(0, ctl(5, 10));
    #1; chk("R2 readback", rdata, 32'h00A0_0050);
    addr = 2'd1; #1; chk("R2 event word reads zero", rdata, 0);
    addr = 2'd0;
  endtask

  task automatic t_levels();
    wr(0, ctl(7, 8));
    oc = 6'b011000; step();
    chk("R4 code7 oc4 high", 32'(trgo), 1);
    chk("R5 code8 oc5 high", 32'(trgo2), 1);
    oc = 6'b001000; step();
    chk("R5 code8 oc5 low", 32'(trgo2), 0);
    chk("R4 code7 oc4 held", 32'(trgo), 1);
    wr(0, ctl(4, 9));
    oc = 6'b100001; step();
    chk("R4 code4 oc1", 32'(trgo), 1);
    chk("R5 code9 oc6", 32'(trgo2), 1);
    wr(0, ctl(1, 1));
    ev_en = 1'b1; step();
    chk("R4 code1 enable", 32'(trgo), 1);
    chk("R5 code1 enable", 32'(trgo2), 1);
    ev_en = 1'b0; oc = '0; step(); step();
    chk("R4 enable low", 32'(trgo), 0);
  endtask

  task automatic t_events();
    wr(0, ctl(0, 3));
    ev_rst = 1'b1; ev_cmp = 1'b1; step();
    chk("R4 code0 reset event", 32'(trgo), 1);
    chk("R5 code3 compare event", 32'(trgo2), 1);
    ev_rst = 1'b0; ev_cmp = 1'b0; step();
    chk("R4 code0 pulse ends", 32'(trgo), 0);
    wr(0, ctl(2, 2));
    ev_upd = 1'b1; step();
    chk("R4 code2 update", 32'(trgo), 1);
    chk("R5 code2 update", 32'(trgo2), 1);
    ev_upd = 1'b0; step();
    chk("R4 code2 update ends", 32'(trgo), 0);
  endtask

  task automatic t_edge_single();
    wr(0, ctl(0, 10));
    oc[3] = 1'b1; step(); chk("R6 code10 oc4 rise", 32'(trgo2), 1);
    step(); chk("R6 code10 one cycle", 32'(trgo2), 0);
    oc[3] = 1'b0; step(); chk("R6 code10 oc4 fall", 32'(trgo2), 1);
    step(); chk("R6 code10 fall one cycle", 32'(trgo2), 0);
    oc[5] = 1'b1; step(); chk("R6 code10 ignores oc6", 32'(trgo2), 0);
    wr(0, ctl(0, 11));
    oc[5] = 1'b0; step(); chk("R6 code11 oc6 fall", 32'(trgo2), 1);
    step(); chk("R6 code11 one cycle", 32'(trgo2), 0);
  endtask

  task automatic t_edge_pairs();
    wr(0, ctl(0, 12));
    oc[3] = 1'b1; step(); chk("R7 code12 oc4 rise", 32'(trgo2), 1);
    step(); step();
    oc[5] = 1'b1; step(); chk("R7 code12 second pulse oc6 rise", 32'(trgo2), 1);
    step(); chk("R7 code12 gap", 32'(trgo2), 0);
    oc[3] = 1'b0; step(); chk("R7 code12 oc4 fall ignored", 32'(trgo2), 0);
    wr(0, ctl(0, 13));
    oc[5] = 1'b0; step(); chk("R7 code13 oc6 fall", 32'(trgo2), 1);
    oc[5] = 1'b1; step(); chk("R7 code13 oc6 rise ignored", 32'(trgo2), 0);
    wr(0, ctl(0, 14));
    oc[4] = 1'b1; step(); chk("R8 code14 oc5 rise", 32'(trgo2), 1);
    oc[5] = 1'b0; step(); chk("R8 code14 oc6 fall ignored", 32'(trgo2), 0);
    oc[5] = 1'b1; step(); chk("R8 code14 oc6 rise", 32'(trgo2), 1);
    wr(0, ctl(0, 15));
    oc[4] = 1'b0; step(); chk("R8 code15 oc5 fall ignored", 32'(trgo2), 0);
    oc[5] = 1'b0; step(); chk("R8 code15 oc6 fall", 32'(trgo2), 1);
    oc[4] = 1'b1; step(); step(); chk("R8 code15 after oc5 rise", 32'(trgo2), 0);
    oc = '0; step(); step();
  endtask

  task automatic t_ug();
    wr(0, ctl(2, 2));
    wr(1, 32'h1);
    chk("R9 no pulse yet", 32'(trgo), 0);
    step();
    chk("R9 trgo update pulse", 32'(trgo), 1);
    chk("R9 trgo2 update pulse", 32'(trgo2), 1);
    chk("R9 absent trgo2 low (R3)", 32'(trgo2_nt), 0);
    step();
    chk("R9 pulse one cycle", 32'(trgo), 0);
    addr = 2'd1; #1; chk("R9 event reads zero", rdata, 0);
    addr = 2'd0;
  endtask

  task automatic t_absent();
    wr(0, 32'hFFFF_FFFF);
    #1; chk("R3 bits 23:20 read zero", rdata_nt & 32'h00F0_0000, 0);
    for (int i = 0; i < 4; i++) begin
      oc = ~oc; step();
      chk("R3 trgo2 stays low", 32'(trgo2_nt), 0);
    end
    oc = '0; step();
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_ctrl_rw();
        t_levels();
        t_events();
        t_edge_single();
        t_edge_pairs();
        t_ug();
        t_absent();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule